// File: doc/BRIEF.md
# Descriptor Chain Walker

The walker follows one channel's linked list of 16-byte buffer descriptors. The list lives in a contiguous table. The table base comes from a register input, and each descriptor names its successor by a 16-bit index into that table. For each descriptor, the walker fetches four 32-bit words through a single-outstanding read port and inspects the two-bit ownership code. When that code says the descriptor is ready, the walker offers the buffer's 64-bit address, its length and its end-of-frame flag to a data mover. When the mover reports that the buffer is finished, the walker reads the successor's first word and marks the finished descriptor as done. The done code also records whether the successor was ready at that moment.

Software builds a chain and ends it with a descriptor marked not-ready. It then pulses `start` with the index of the first entry. When the walker reaches a not-ready entry it parks there, and it polls that entry again only when it receives a `resume` strobe. A descriptor that is already marked done when it is fetched means the chain is corrupt. The walker reports this on `chain_err` and stops until the next `start`.

Top module: `dwk_walker`

## Requirements
- R1: After reset, `rd_req_valid`, `buf_valid`, `wr_valid`, `stalled` and `chain_err` are all low.
- R2: `start` loads `start_idx`. The walker then reads four words in order at B+16*idx+0, +4, +8 and +12, where B is `area_base` with bits 3:0 forced to zero. Only one read is outstanding at a time, and the returned word is taken when `rd_rsp_valid` and `rd_rsp_ready` are both high.
- R3: Word 0 carries the ownership code in bits 1:0, end-of-frame in bit 4 and the successor index in bits 31:16. Word 1 is the buffer length, word 2 the low address word and word 3 the high address word. With code 3 (ready), the walker offers `buf_addr`={word3,word2}, `buf_len`=word1 and `buf_eof`=word0 bit 4.
- R4: With code 2 (not ready), the walker raises `stalled` and issues no traffic. A `resume` strobe re-reads all four words of the same descriptor.
- R5: With code 0 or 1 (already done), the walker raises `chain_err` and issues no traffic. `resume` has no effect in this state, and only `start` leaves it.
- R6: After `buf_done`, the walker makes exactly one read, of word 0 of the successor, at B+16*successor.
- R7: The walker then writes word 0 of the finished descriptor with bits 31:2 unchanged. Bits 1:0 become 0 if the successor's code read 3, and 1 otherwise.
- R8: After writing code 0, the walker fetches the successor in full. After writing code 1, it parks on the successor with `stalled` high, and `resume` fetches that successor.
- R9: A pending read request keeps `rd_addr` stable until accepted. A pending buffer offer keeps its address, length and flag stable until accepted.
- R10: `start` is ignored unless the walker is idle, stalled or in error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Begin walking at `start_idx` |
| start_idx | input | IDX_W | Index of the first descriptor |
| resume | input | 1 | Re-poll the parked descriptor |
| area_base | input | ADDR_W | Descriptor table base address |
| rd_req_valid | output | 1 | Read request pending |
| rd_req_ready | input | 1 | Memory accepts the request |
| rd_addr | output | ADDR_W | Read word address (byte units) |
| rd_rsp_valid | input | 1 | Read data present |
| rd_rsp_ready | output | 1 | Walker takes read data |
| rd_rsp_data | input | DATA_W | Read data word |
| buf_valid | output | 1 | Buffer offered to the mover |
| buf_ready | input | 1 | Mover accepts the offer |
| buf_addr | output | 2*DATA_W | Buffer physical address |
| buf_len | output | DATA_W | Buffer length |
| buf_eof | output | 1 | End-of-frame flag |
| buf_done | input | 1 | Mover finished the buffer |
| wr_valid | output | 1 | Write-back pending |
| wr_ready | input | 1 | Memory accepts the write |
| wr_addr | output | ADDR_W | Write-back address |
| wr_data | output | DATA_W | Updated word 0 |
| stalled | output | 1 | Parked on a not-ready descriptor |
| chain_err | output | 1 | Done descriptor found at fetch |

## Verification
A wrong index or word counter shows up on `rd_addr` at the next request, one cycle after the previous response is taken. A lost peek result shows up as the wrong low two bits of `wr_data` at the next write-back. A wrong state decode either leaves `stalled` or `chain_err` high while traffic continues, or lets a request appear after a park. The bench sees each of these within a few cycles of the event. Because its memory model applies every write-back, a corrupted done code also changes the path of later chains.

// File: rtl/dwk_pkg.sv
package dwk_pkg;
   typedef enum logic [1:0] {
      SY_DONE_LINK   = 2'd0,
      SY_DONE_NOLINK = 2'd1,
      SY_HOLD        = 2'd2,
      SY_READY       = 2'd3
   } sync_e;

   typedef enum logic [2:0] {
      ST_IDLE, ST_RREQ, ST_RRSP, ST_OFFER, ST_XFER, ST_WBACK, ST_PARK, ST_FAULT
   } walk_st_e;

   localparam int DESC_WORDS    = 4;
   localparam int DESC_BYTES_LG = 4;
   localparam int SYNC_LSB      = 0;
   localparam int EOF_BIT       = 4;
   localparam int NEXT_LSB      = 16;
endpackage

// File: rtl/dwk_addr.sv
module dwk_addr import dwk_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 16,
   parameter int WSEL_W      = 2,
   parameter bit FORCE_ALIGN = 1'b1
) (
   input  logic [ADDR_W-1:0] base,
   input  logic [IDX_W-1:0]  idx,
   input  logic [WSEL_W-1:0] wsel,
   output logic [ADDR_W-1:0] addr
);
   localparam logic [ADDR_W-1:0] LOW_MASK = ADDR_W'((1 << DESC_BYTES_LG) - 1);

   logic [ADDR_W-1:0] base_eff;

   generate
      if (FORCE_ALIGN) begin : g_mask
         assign base_eff = base & ~LOW_MASK;
      end else begin : g_raw
         assign base_eff = base;
      end
   endgenerate

   assign addr = base_eff + (ADDR_W'(idx) << DESC_BYTES_LG) + (ADDR_W'(wsel) << 2);
endmodule

// File: rtl/dwk_capture.sv
module dwk_capture #(
   parameter int DATA_W = 32,
   parameter int NWORDS = 4,
   parameter int SEL_W  = $clog2(NWORDS)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     load,
   input  logic [SEL_W-1:0]         sel,
   input  logic [DATA_W-1:0]        din,
   output logic [NWORDS*DATA_W-1:0] words
);
   generate
      for (genvar i = 0; i < NWORDS; i++) begin : g_word
         logic [DATA_W-1:0] q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
               q <= '0;
            else if (load && (sel == SEL_W'(i)))
               q <= din;
         end
         assign words[i*DATA_W +: DATA_W] = q;
      end
   endgenerate
endmodule

// File: rtl/dwk_walker.sv
module dwk_walker import dwk_pkg::*; #(
   parameter int ADDR_W      = 32,
   parameter int IDX_W       = 16,
   parameter int DATA_W      = 32,
   parameter bit FORCE_ALIGN = 1'b1
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                start,
   input  logic [IDX_W-1:0]    start_idx,
   input  logic                resume,
   input  logic [ADDR_W-1:0]   area_base,
   output logic                rd_req_valid,
   input  logic                rd_req_ready,
   output logic [ADDR_W-1:0]   rd_addr,
   input  logic                rd_rsp_valid,
   output logic                rd_rsp_ready,
   input  logic [DATA_W-1:0]   rd_rsp_data,
   output logic                buf_valid,
   input  logic                buf_ready,
   output logic [2*DATA_W-1:0] buf_addr,
   output logic [DATA_W-1:0]   buf_len,
   output logic                buf_eof,
   input  logic                buf_done,
   output logic                wr_valid,
   input  logic                wr_ready,
   output logic [ADDR_W-1:0]   wr_addr,
   output logic [DATA_W-1:0]   wr_data,
   output logic                stalled,
   output logic                chain_err
);
   localparam int WSEL_W = $clog2(DESC_WORDS);
   localparam logic [WSEL_W-1:0] LAST_WORD = WSEL_W'(DESC_WORDS - 1);

   generate
      if (DATA_W < NEXT_LSB + IDX_W) begin : g_bad_idx
         $error("dwk_walker: successor index does not fit in word 0");
      end
      if (ADDR_W < IDX_W + DESC_BYTES_LG) begin : g_bad_addr
         $error("dwk_walker: address too narrow for descriptor table");
      end
   endgenerate

   walk_st_e                   st;
   logic [IDX_W-1:0]           cur_idx;
   logic [WSEL_W-1:0]          wcnt;
   logic                       peek;
   logic                       link_ok;
   logic [DESC_WORDS*DATA_W-1:0] dwords;
   logic [DATA_W-1:0]          w0, w1, w2, w3;
   logic [IDX_W-1:0]           nxt_idx;
   logic [IDX_W-1:0]           rd_idx;
   logic [WSEL_W-1:0]          rd_wsel;
   logic                       cap_load;
   logic                       can_start;

   assign w0      = dwords[0*DATA_W +: DATA_W];
   assign w1      = dwords[1*DATA_W +: DATA_W];
   assign w2      = dwords[2*DATA_W +: DATA_W];
   assign w3      = dwords[3*DATA_W +: DATA_W];
   assign nxt_idx = w0[NEXT_LSB +: IDX_W];

   assign rd_idx   = peek ? nxt_idx : cur_idx;
   assign rd_wsel  = peek ? '0 : wcnt;
   assign cap_load = (st == ST_RRSP) && rd_rsp_valid && !peek;
   assign can_start = (st == ST_IDLE) || (st == ST_PARK) || (st == ST_FAULT);

   dwk_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .FORCE_ALIGN(FORCE_ALIGN)
   ) u_rd_addr (
      .base(area_base), .idx(rd_idx), .wsel(rd_wsel), .addr(rd_addr)
   );

   dwk_addr #(
      .ADDR_W(ADDR_W), .IDX_W(IDX_W), .WSEL_W(WSEL_W), .FORCE_ALIGN(FORCE_ALIGN)
   ) u_wr_addr (
      .base(area_base), .idx(cur_idx), .wsel('0), .addr(wr_addr)
   );

   dwk_capture #(
      .DATA_W(DATA_W), .NWORDS(DESC_WORDS), .SEL_W(WSEL_W)
   ) u_capture (
      .clk(clk), .rst_n(rst_n), .load(cap_load), .sel(wcnt),
      .din(rd_rsp_data), .words(dwords)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= ST_IDLE;
         cur_idx <= '0;
         wcnt    <= '0;
         peek    <= 1'b0;
         link_ok <= 1'b0;
      end else begin
         if (can_start && start) begin
            cur_idx <= start_idx;
            wcnt    <= '0;
            peek    <= 1'b0;
            st      <= ST_RREQ;
         end else begin
            unique case (st)
               ST_PARK: begin
                  if (resume) begin
                     wcnt <= '0;
                     peek <= 1'b0;
                     st   <= ST_RREQ;
                  end
               end
               ST_RREQ: begin
                  if (rd_req_ready) st <= ST_RRSP;
               end
               ST_RRSP: begin
                  if (rd_rsp_valid) begin
                     if (peek) begin
                        link_ok <= (rd_rsp_data[SYNC_LSB +: 2] == SY_READY);
                        st      <= ST_WBACK;
                     end else if (wcnt == LAST_WORD) begin
                        case (w0[SYNC_LSB +: 2])
                           SY_READY: st <= ST_OFFER;
                           SY_HOLD:  st <= ST_PARK;
                           default:  st <= ST_FAULT;
                        endcase
                     end else begin
                        wcnt <= wcnt + 1'b1;
                        st   <= ST_RREQ;
                     end
                  end
               end
               ST_OFFER: begin
                  if (buf_ready) st <= ST_XFER;
               end
               ST_XFER: begin
                  if (buf_done) begin
                     peek <= 1'b1;
                     st   <= ST_RREQ;
                  end
               end
               ST_WBACK: begin
                  if (wr_ready) begin
                     cur_idx <= nxt_idx;
                     peek    <= 1'b0;
                     wcnt    <= '0;
                     st      <= link_ok ? ST_RREQ : ST_PARK;
                  end
               end
               default: ;
            endcase
         end
      end
   end

   assign rd_req_valid = (st == ST_RREQ);
   assign rd_rsp_ready = (st == ST_RRSP);
   assign buf_valid    = (st == ST_OFFER);
   assign buf_addr     = {w3, w2};
   assign buf_len      = w1;
   assign buf_eof      = w0[EOF_BIT];
   assign wr_valid     = (st == ST_WBACK);
   assign wr_data      = {w0[DATA_W-1:2], link_ok ? 2'(SY_DONE_LINK) : 2'(SY_DONE_NOLINK)};
   assign stalled      = (st == ST_PARK);
   assign chain_err    = (st == ST_FAULT);
endmodule

// File: rtl/dwk_walker_chk.sv
module dwk_walker_chk #(
   parameter int ADDR_W = 32,
   parameter int DATA_W = 32
) (
   input logic                clk,
   input logic                rst_n,
   input logic                start,
   input logic                resume,
   input logic                rd_req_valid,
   input logic                rd_req_ready,
   input logic [ADDR_W-1:0]   rd_addr,
   input logic                rd_rsp_valid,
   input logic                rd_rsp_ready,
   input logic                buf_valid,
   input logic                buf_ready,
   input logic [2*DATA_W-1:0] buf_addr,
   input logic [DATA_W-1:0]   buf_len,
   input logic                wr_valid,
   input logic [DATA_W-1:0]   wr_data,
   input logic                stalled,
   input logic                chain_err
);
   AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      rd_req_valid && !rd_req_ready |=> rd_req_valid && $stable(rd_addr))
      else $error("read request dropped or moved"); // R9

   AST_OFFER_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      buf_valid && !buf_ready |=> buf_valid && $stable(buf_addr) && $stable(buf_len))
      else $error("buffer offer dropped or moved"); // R9

   AST_OFFER_AFTER_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(buf_valid) |-> $past(rd_rsp_valid && rd_rsp_ready))
      else $error("offer without a completed fetch"); // R3

   AST_WB_AFTER_PEEK: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(wr_valid) |-> $past(rd_rsp_valid && rd_rsp_ready))
      else $error("write-back without a successor read"); // R6

   AST_WB_DONE_CODE: assert property (@(posedge clk) disable iff (!rst_n)
      wr_valid |-> !wr_data[1])
      else $error("write-back code is not a done code"); // R7

   AST_PARK_STAYS: assert property (@(posedge clk) disable iff (!rst_n)
      stalled && !start && !resume |=> stalled)
      else $error("left park without a strobe"); // R4

   AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
      chain_err && !start |=> chain_err)
      else $error("left error without start"); // R5

   AST_ONE_ACTIVITY: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rd_req_valid, buf_valid, wr_valid, stalled, chain_err}))
      else $error("more than one activity at once"); // R4
endmodule

bind dwk_walker dwk_walker_chk #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .start(start), .resume(resume),
   .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_addr(rd_addr),
   .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
   .buf_valid(buf_valid), .buf_ready(buf_ready), .buf_addr(buf_addr), .buf_len(buf_len),
   .wr_valid(wr_valid), .wr_data(wr_data), .stalled(stalled), .chain_err(chain_err)
);

// File: tb/dwk_walker_test.sv
`timescale 1ns/1ps
module dwk_walker_test;
   localparam logic [31:0] BASE_AL = 32'h0004_A200;
   localparam logic [31:0] BASE_IN = 32'h0004_A20B;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic [15:0] start_idx = '0;
   logic        resume = 1'b0;
   logic [31:0] area_base = BASE_IN;
   logic        rd_req_valid, rd_req_ready = 1'b0;
   logic [31:0] rd_addr;
   logic        rd_rsp_valid = 1'b0, rd_rsp_ready;
   logic [31:0] rd_rsp_data = '0;
   logic        buf_valid, buf_ready = 1'b0;
   logic [63:0] buf_addr;
   logic [31:0] buf_len;
   logic        buf_eof;
   logic        buf_done = 1'b0;
   logic        wr_valid, wr_ready = 1'b0;
   logic [31:0] wr_addr, wr_data;
   logic        stalled, chain_err;

   always #2 clk = ~clk;

   dwk_walker uut (
      .clk(clk), .rst_n(rst_n), .start(start), .start_idx(start_idx), .resume(resume),
      .area_base(area_base), .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready),
      .rd_addr(rd_addr), .rd_rsp_valid(rd_rsp_valid), .rd_rsp_ready(rd_rsp_ready),
      .rd_rsp_data(rd_rsp_data), .buf_valid(buf_valid), .buf_ready(buf_ready),
      .buf_addr(buf_addr), .buf_len(buf_len), .buf_eof(buf_eof), .buf_done(buf_done),
      .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
      .stalled(stalled), .chain_err(chain_err)
   );

   int errs = 0;
   int checks = 0;
   int hold_bad = 0;
   int last_idx = 0;

   logic [31:0] mem [0:4095];
   logic [31:0] rlog[$];
   logic [31:0] wla[$];
   logic [31:0] wld[$];
   logic [63:0] oad[$];
   logic [31:0] olen[$];
   logic        oeof[$];

   function automatic int mi(logic [31:0] a);
      return int'(((a - BASE_AL) >> 2) & 32'hFFF);
   endfunction

   function automatic logic [31:0] da(int idx);
      return BASE_AL + 32'(idx) * 32'd16;
   endfunction

   function automatic logic [31:0] mk_w0(int nxt, bit eof, logic [1:0] sy, logic [31:0] fill);
      return {nxt[15:0], fill[10:0], eof, fill[12:11], sy};
   endfunction

   task automatic chk(input string req, input string what, input logic [63:0] act, input logic [63:0] exp);
      checks++;
      if (act !== exp) begin
         errs++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic clear_logs();
      rlog.delete(); wla.delete(); wld.delete();
      oad.delete(); olen.delete(); oeof.delete();
   endtask

   task automatic pulse_start(input int idx);
      @(posedge clk); #1;
      start_idx = 16'(idx);
      start = 1'b1;
      @(posedge clk); #1;
      start = 1'b0;
   endtask

   task automatic pulse_resume();
      @(posedge clk); #1;
      resume = 1'b1;
      @(posedge clk); #1;
      resume = 1'b0;
   endtask

   task automatic wait_end();
      do @(negedge clk); while (!(stalled || chain_err));
   endtask

   // Memory, data mover and handshake monitor
   initial begin
      bit rpend = 0, racc = 0, xpend = 0, rwait = 0, owait = 0;
      int rdly = 0, xdly = 0;
      logic [31:0] raddr = '0, rwait_a = '0;
      logic [96:0] owait_v = '0;
      forever begin
         @(negedge clk);
         if (rwait && (!rd_req_valid || rd_addr !== rwait_a)) hold_bad++;
         if (owait && (!buf_valid || {buf_addr, buf_len, buf_eof} !== owait_v)) hold_bad++;
         rwait   = rd_req_valid && !rd_req_ready;
         rwait_a = rd_addr;
         owait   = buf_valid && !buf_ready;
         owait_v = {buf_addr, buf_len, buf_eof};
         if (rd_req_valid && rd_req_ready) begin
            rlog.push_back(rd_addr);
            rpend = 1; raddr = rd_addr; rdly = int'($urandom % 3);
         end
         if (rd_rsp_valid && rd_rsp_ready) racc = 1;
         if (wr_valid && wr_ready) begin
            wla.push_back(wr_addr); wld.push_back(wr_data);
            mem[mi(wr_addr)] = wr_data;
         end
         if (buf_valid && buf_ready) begin
            oad.push_back(buf_addr); olen.push_back(buf_len); oeof.push_back(buf_eof);
            xpend = 1; xdly = int'($urandom % 4);
         end
         @(posedge clk); #1;
         rd_req_ready = ($urandom % 4) != 0;
         wr_ready     = ($urandom % 3) != 0;
         buf_ready    = ($urandom % 3) != 0;
         if (racc) begin rd_rsp_valid = 1'b0; racc = 0; end
         if (rpend && !rd_rsp_valid) begin
            if (rdly == 0) begin
               rd_rsp_valid = 1'b1; rd_rsp_data = mem[mi(raddr)]; rpend = 0;
            end else rdly--;
         end
         buf_done = 1'b0;
         if (xpend) begin
            if (xdly == 0) begin buf_done = 1'b1; xpend = 0; end
            else xdly--;
         end
      end
   end

   task automatic run_chain(input int n, input bit poke);
      int ix[8];
      logic [31:0] w0s[8], w1s[8], w2s[8], w3s[8];
      int s0 = int'($urandom % 900);
      int g = n - 1;
      for (int k = 0; k < n; k++) ix[k] = s0 + 13 * k;
      for (int k = 0; k < n; k++) begin
         w0s[k] = mk_w0((k == n - 1) ? int'($urandom % 1024) : ix[k + 1], bit'($urandom % 2),
                        (k == n - 1) ? 2'd2 : 2'd3, $urandom);
         w1s[k] = $urandom; w2s[k] = $urandom; w3s[k] = $urandom;
         mem[ix[k]*4]   = w0s[k]; mem[ix[k]*4+1] = w1s[k];
         mem[ix[k]*4+2] = w2s[k]; mem[ix[k]*4+3] = w3s[k];
      end
      clear_logs();
      pulse_start(ix[0]);
      if (poke) begin
         do @(negedge clk); while (!buf_valid);
         pulse_start((ix[0] + 500) % 1024);   // R10: must be ignored mid-walk
      end
      wait_end();
      chk("R8", "read count", 64'(rlog.size()), 64'(5 * g));
      if (poke) chk("R10", "reads after mid-walk start", 64'(rlog.size()), 64'(5 * g));
      if (rlog.size() == 5 * g) begin
         for (int k = 0; k < g; k++) begin
            for (int j = 0; j < 4; j++)
               chk("R2", "fetch address", 64'(rlog[5*k+j]), 64'(da(ix[k]) + 32'(4*j)));
            chk("R6", "successor peek address", 64'(rlog[5*k+4]), 64'(da(ix[k+1])));
         end
      end
      chk("R3", "offer count", 64'(oad.size()), 64'(g));
      if (oad.size() == g) begin
         for (int k = 0; k < g; k++) begin
            chk("R3", "buffer address", oad[k], {w3s[k], w2s[k]});
            chk("R3", "buffer length", 64'(olen[k]), 64'(w1s[k]));
            chk("R3", "end-of-frame", 64'(oeof[k]), 64'(w0s[k][4]));
         end
      end
      chk("R7", "write count", 64'(wla.size()), 64'(g));
      if (wla.size() == g) begin
         for (int k = 0; k < g; k++) begin
            chk("R7", "write address", 64'(wla[k]), 64'(da(ix[k])));
            chk("R7", "write data", 64'(wld[k]),
                64'({w0s[k][31:2], (k < g - 1) ? 2'b00 : 2'b01}));
         end
      end
      chk("R8", "parked at chain end", 64'(stalled), 64'(1));
      chk("R5", "no error on clean chain", 64'(chain_err), 64'(0));
      last_idx = ix[n-1];
   endtask

   task automatic resume_extend();
      int x = (last_idx + 300) % 1024;
      logic [31:0] w0 = mk_w0(x, 1'b1, 2'd3, $urandom);
      logic [31:0] w1 = $urandom, w2 = $urandom, w3 = $urandom;
      mem[last_idx*4] = w0; mem[last_idx*4+1] = w1;
      mem[last_idx*4+2] = w2; mem[last_idx*4+3] = w3;
      mem[x*4] = mk_w0(int'($urandom % 1024), 1'b0, 2'd2, $urandom);
      clear_logs();
      pulse_resume();
      wait_end();
      chk("R8", "reads after resume", 64'(rlog.size()), 64'(5));
      if (rlog.size() == 5) begin
         for (int j = 0; j < 4; j++)
            chk("R8", "refetch address", 64'(rlog[j]), 64'(da(last_idx) + 32'(4*j)));
         chk("R6", "peek address", 64'(rlog[4]), 64'(da(x)));
      end
      chk("R3", "offer count after resume", 64'(oad.size()), 64'(1));
      if (oad.size() == 1) chk("R3", "buffer address", oad[0], {w3, w2});
      chk("R7", "write count after resume", 64'(wla.size()), 64'(1));
      if (wld.size() == 1) chk("R7", "invalid-link write", 64'(wld[0]), 64'({w0[31:2], 2'b01}));
      chk("R8", "parked on successor", 64'(stalled), 64'(1));
      last_idx = x;
   endtask

   task automatic hold_test();
      int h = 700;
      mem[h*4] = mk_w0(5, 1'b0, 2'd2, $urandom);
      clear_logs();
      pulse_start(h);
      wait_end();
      chk("R4", "reads before park", 64'(rlog.size()), 64'(4));
      if (rlog.size() == 4)
         for (int j = 0; j < 4; j++)
            chk("R4", "hold fetch address", 64'(rlog[j]), 64'(da(h) + 32'(4*j)));
      chk("R4", "no offer while held", 64'(oad.size()), 64'(0));
      repeat (40) @(negedge clk);
      chk("R4", "no polling without resume", 64'(rlog.size()), 64'(4));
      pulse_resume();
      wait_end();
      chk("R4", "resume refetch count", 64'(rlog.size()), 64'(8));
      if (rlog.size() == 8) chk("R4", "refetch same descriptor", 64'(rlog[4]), 64'(da(h)));
      chk("R4", "still parked", 64'(stalled), 64'(1));
   endtask

   task automatic fault_test(input logic [1:0] sy);
      int f = 800 + int'(sy);
      mem[f*4] = mk_w0(9, 1'b1, sy, $urandom);
      clear_logs();
      pulse_start(f);
      wait_end();
      chk("R5", "error raised", 64'(chain_err), 64'(1));
      chk("R5", "reads before error", 64'(rlog.size()), 64'(4));
      chk("R5", "no offer on done descriptor", 64'(oad.size()), 64'(0));
      chk("R5", "no write on done descriptor", 64'(wla.size()), 64'(0));
      pulse_resume();
      repeat (30) @(negedge clk);
      chk("R5", "resume ignored in error", 64'(rlog.size()), 64'(4));
      chk("R5", "error held", 64'(chain_err), 64'(1));
   endtask

   initial begin
      int seed = int'($urandom(32'd7411));
      repeat (4) @(posedge clk);
      #1 rst_n = 1'b1;
      @(negedge clk);
      chk("R1", "read idle", 64'(rd_req_valid), 64'(0));
      chk("R1", "offer idle", 64'(buf_valid), 64'(0));
      chk("R1", "write idle", 64'(wr_valid), 64'(0));
      chk("R1", "stalled clear", 64'(stalled), 64'(0));
      chk("R1", "error clear", 64'(chain_err), 64'(0));
      run_chain(2, 1'b0);
      resume_extend();
      hold_test();
      fault_test(2'd0);
      fault_test(2'd1);
      for (int it = 0; it < 6; it++) begin
         run_chain(2 + int'($urandom % 5), 1'b0);
         resume_extend();
      end
      run_chain(4, 1'b1);
      chk("R9", "handshake stability violations", 64'(hold_bad), 64'(0));
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      checks++;
      errs++;
      $display("FAIL R8 watchdog expired: cycles=%0d expected below %0d", 150000, 150000);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
   end
endmodule